// File: doc/BRIEF.md
# Cyclic Prefix Inserter and Word Serializer

This block sits between an 8-point inverse transform and a digital up-converter on the transmit path of a multicarrier modem. It accepts one complete time-domain symbol as a single parallel word: 16 samples of 16 bits, with real and imaginary parts of each point interleaved. It builds a guard-extended frame by copying the final three 16-bit words of the symbol, 48 bits in all, ahead of the whole 256-bit symbol. The result is a 304-bit frame. A sequencing counter then walks a shift register and emits that frame as nineteen 16-bit words, one per clock.

The input side is a valid/ready handshake. A symbol is taken on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the upstream stage must hold off, and any `in_valid` it raises has no effect. The output side has no back-pressure: the up-converter consumes one word per clock, so `out_valid` marks each word and the output cannot be stalled. `in_ready` rises again in the cycle that carries the final word of a frame. A symbol offered in that cycle is taken, so frames can run back to back with no gap.

Top module: `cp_frame_serializer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `out_data` is 0.
- R2: The first three words of a frame are symbol words 13, 14 and 15, in that order. Symbol word k occupies `in_symbol[16k+15:16k]`.
- R3: Frame words 3 to 18 are symbol words 0 to 15, in ascending order.
- R4: The first frame word appears on `out_data` with `out_valid` high in the cycle right after the accepting clock edge.
- R5: For each accepted symbol, `out_valid` is high for exactly 19 consecutive cycles. If no new symbol is accepted, it is low afterwards.
- R6: While frame words 0 to 17 are on the output, `in_ready` is 0. An `in_valid` raised then neither alters the running frame nor starts another one.
- R7: `in_ready` is 1 while frame word 18 is on the output. A symbol accepted in that cycle starts its word 0 on the next cycle, so `out_valid` never drops between the two frames.
- R8: Asserting the active-low `rst_n` clears `out_valid` and `out_data` at once, without waiting for a clock edge, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream offers a symbol |
| in_ready | output | 1 | Block can take a symbol this cycle |
| in_symbol | input | 256 | Symbol, word k at bits 16k+15:16k |
| out_valid | output | 1 | `out_data` carries a frame word |
| out_data | output | 16 | Current frame word |

## Verification
The emission of the last word of one frame and the acceptance of the next symbol can happen in the same cycle. The bench provokes this by raising `in_valid` exactly while word 18 is on the output. It then judges that word 18 still carries the old symbol's last word, that `in_ready` is high in that cycle, and that the new frame's first prefix word follows on the very next cycle with `out_valid` unbroken. The bench also holds `in_valid` high through words 5 to 17 of a frame. It confirms that the frame is unchanged and that no second frame appears afterwards.

// File: rtl/cpser_pkg.sv
package cpser_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } seq_state_t;

  function automatic int unsigned frame_words(input int unsigned sym_words,
                                              input int unsigned cp_words);
    return sym_words + cp_words;
  endfunction
endpackage

// File: rtl/cpser_frame_build.sv
module cpser_frame_build #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned SYM_WORDS = 16,
  parameter int unsigned CP_WORDS  = 3
) (
  input  logic [SYM_WORDS*WORD_W-1:0]              sym,
  output logic [(SYM_WORDS+CP_WORDS)*WORD_W-1:0]   frame
);
  localparam int unsigned FRAME_WORDS = cpser_pkg::frame_words(SYM_WORDS, CP_WORDS);
  localparam int unsigned TAIL_BASE   = SYM_WORDS - CP_WORDS;

  // Frame word 0 is sent first; the guard copy of the symbol tail leads.
  for (genvar i = 0; i < FRAME_WORDS; i++) begin : g_word
    if (i < CP_WORDS) begin : g_guard
      assign frame[i*WORD_W +: WORD_W] = sym[(TAIL_BASE+i)*WORD_W +: WORD_W];
    end else begin : g_body
      assign frame[i*WORD_W +: WORD_W] = sym[(i-CP_WORDS)*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/cpser_shifter.sv
module cpser_shifter #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned WORDS  = 19
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      shift,
  input  logic [WORDS*WORD_W-1:0]   frame_in,
  output logic [WORD_W-1:0]         word_out
);
  localparam int unsigned TOTAL_W = WORDS * WORD_W;

  logic [TOTAL_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (load) begin
      shreg <= frame_in;
    end else if (shift) begin
      shreg <= {{WORD_W{1'b0}}, shreg[TOTAL_W-1:WORD_W]};
    end
  end

  assign word_out = shreg[WORD_W-1:0];

  // R3: each shift presents the word that stood next in line
  a_r3_next_word: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (word_out == $past(shreg[2*WORD_W-1:WORD_W])));
endmodule

// File: rtl/cpser_seq.sv
module cpser_seq #(
  parameter int unsigned FRAME_WORDS = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_req,
  output logic in_ready,
  output logic load_en,
  output logic shift_en,
  output logic active
);
  import cpser_pkg::*;

  localparam int unsigned CNT_W = $clog2(FRAME_WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_WORDS - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign active   = (state == ST_SHIFT);
  assign in_ready = (state == ST_IDLE) || (cnt == LAST);
  assign load_en  = load_req && in_ready;
  assign shift_en = active && !load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (load_en) begin
      state <= ST_SHIFT;
      cnt   <= '0;
    end else if (state == ST_SHIFT) begin
      if (cnt == LAST) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: an accepted symbol starts at word 0 on the next cycle
  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (active && cnt == '0));
  // R5: a running frame advances one word per cycle
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != LAST) |=> (active && cnt == $past(cnt) + 1'b1));
  // R5: the frame ends after its last word unless a new one was taken
  a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == LAST && !load_req) |=> !active);
  // R6: a strobe during words 0..17 does not restart the count
  a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != LAST && load_req) |=> (cnt != '0));
endmodule

// File: rtl/cp_frame_serializer.sv
module cp_frame_serializer #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned N_POINTS = 8,
  parameter int unsigned CP_WORDS = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [2*N_POINTS*SAMPLE_W-1:0]  in_symbol,
  output logic                            out_valid,
  output logic [SAMPLE_W-1:0]             out_data
);
  localparam int unsigned SYM_WORDS   = 2 * N_POINTS;
  localparam int unsigned FRAME_WORDS = cpser_pkg::frame_words(SYM_WORDS, CP_WORDS);
  localparam int unsigned FRAME_W     = FRAME_WORDS * SAMPLE_W;
  localparam int unsigned GUARD_LSB   = (SYM_WORDS - CP_WORDS) * SAMPLE_W;

  logic               load_en;
  logic               shift_en;
  logic [FRAME_W-1:0] frame;

  cpser_frame_build #(
    .WORD_W   (SAMPLE_W),
    .SYM_WORDS(SYM_WORDS),
    .CP_WORDS (CP_WORDS)
  ) u_build (
    .sym  (in_symbol),
    .frame(frame)
  );

  cpser_seq #(
    .FRAME_WORDS(FRAME_WORDS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_req(in_valid),
    .in_ready(in_ready),
    .load_en (load_en),
    .shift_en(shift_en),
    .active  (out_valid)
  );

  cpser_shifter #(
    .WORD_W(SAMPLE_W),
    .WORDS (FRAME_WORDS)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_en),
    .shift   (shift_en),
    .frame_in(frame),
    .word_out(out_data)
  );

  // R2: the first word after acceptance is the first guard word
  a_r2_guard_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (out_valid && out_data == $past(in_symbol[GUARD_LSB +: SAMPLE_W])));
  // R6: a strobe that meets a busy block never restarts the frame
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> out_valid);
endmodule

// File: tb/sim_cp_frame_serializer.sv
module sim_cp_frame_serializer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_symbol = '0;
  logic         out_valid;
  logic [15:0]  out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cp_frame_serializer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_symbol(in_symbol), .out_valid(out_valid), .out_data(out_data)
  );

  // {base, step, expected first word, expected last word}
  localparam logic [63:0] VEC [0:3] = '{
    64'h1000_0001_100D_100F,
    64'h0000_1111_DDDD_FFFF,
    64'hFFFF_FFFF_FFF2_FFF0,
    64'h8000_0100_8D00_8F00
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk_sym(input logic [15:0] base, input logic [15:0] step);
    logic [255:0] s;
    for (int k = 0; k < 16; k++) s[16*k +: 16] = base + 16'(k) * step;
    return s;
  endfunction

  // Frame order from R2 and R3
  function automatic logic [15:0] exp_word(input logic [255:0] s, input int i);
    if (i < 3) return s[16*(13+i) +: 16];
    return s[16*(i-3) +: 16];
  endfunction

  // inj: -1 none, 0..17 hold a strobe with alt from word inj to 17 (R6),
  // 18 offer alt during word 18 (R7). preloaded: the load was already taken.
  task automatic play(input logic [255:0] s, input logic [255:0] alt, input int inj,
                      input bit preloaded);
    if (!preloaded) begin
      in_symbol = s;
      in_valid  = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int i = 0; i < 19; i++) begin
      chk(out_valid === 1'b1, "R5 valid during frame", 32'(out_valid), 1);
      chk(out_data === exp_word(s, i), (i < 3) ? "R2 guard word" : "R3 body word",
          32'(out_data), 32'(exp_word(s, i)));
      chk(in_ready === (i == 18), (i == 18) ? "R7 ready on last word" : "R6 busy",
          32'(in_ready), 32'(i == 18));
      if ((inj >= 0 && inj < 18 && i >= inj && i < 18) || (inj == 18 && i == 18)) begin
        in_symbol = alt;
        in_valid  = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    if (inj != 18) begin
      in_valid = 1'b0;
      chk(out_valid === 1'b0, "R5 valid low after frame", 32'(out_valid), 0);
      chk(in_ready === 1'b1, "R5 ready after frame", 32'(in_ready), 1);
    end
  endtask

  initial begin
    logic [255:0] a;
    logic [255:0] b;
    #25;
    chk(out_valid === 1'b0, "R1 reset valid", 32'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 reset ready", 32'(in_ready), 1);
    chk(out_data === 16'h0, "R1 reset data", 32'(out_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk (R2, R3, R4, R5)
    for (int v = 0; v < 4; v++) begin
      a = mk_sym(VEC[v][63:48], VEC[v][47:32]);
      in_symbol = a;
      in_valid  = 1'b1;
      @(negedge clk);
      chk(out_data === VEC[v][31:16], "R4 first word next cycle", 32'(out_data),
          32'(VEC[v][31:16]));
      play(a, '0, -1, 1'b1);
      // after play: compare remembered last word via expected table
      chk(exp_word(a, 18) === VEC[v][15:0], "R3 table last word", 32'(exp_word(a, 18)),
          32'(VEC[v][15:0]));
      @(negedge clk);
    end

    // R6: strobe held through words 5..17 is ignored
    a = mk_sym(16'h0A00, 16'h0011);
    b = mk_sym(16'h5500, 16'h0003);
    play(a, b, 5, 1'b0);
    for (int j = 0; j < 3; j++) begin
      chk(out_valid === 1'b0, "R6 no extra frame", 32'(out_valid), 0);
      @(negedge clk);
    end

    // R7: back-to-back frames with load on the final word
    play(a, b, 18, 1'b0);
    chk(out_valid === 1'b1, "R7 valid unbroken", 32'(out_valid), 1);
    chk(out_data === exp_word(b, 0), "R7 next frame first word", 32'(out_data),
        32'(exp_word(b, 0)));
    play(b, '0, -1, 1'b1);

    // R8: asynchronous reset in mid-frame
    in_symbol = a;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (7) @(negedge clk);
    #3 rst_n = 1'b0;
    #2;
    chk(out_valid === 1'b0, "R8 async clear valid", 32'(out_valid), 0);
    chk(out_data === 16'h0, "R8 async clear data", 32'(out_data), 0);
    chk(in_ready === 1'b1, "R8 ready after reset", 32'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    play(b, '0, -1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule